// File: doc/BRIEF.md
# Double-Rate Read Burst Strobe Sequencer

This block is the read path on the memory side of a double-data-rate SDRAM. It takes a decoded READ command made up of a bank number, a starting column and an auto-precharge flag. It waits out the configured CAS latency and then drives a data strobe and a burst of data words. When the command asked for it, the block reports which bank's open row must be closed once the burst is over. Double-rate timing is modelled on one clock `clk` that runs at twice the command rate. Commands are accepted only on every second rising edge of `clk`, the command edges. The first command edge is the first rising edge after reset is released.

A fixed pattern stands in for the memory array: each word is derived from the bank and the column it is read from. The strobe sequence is a low preamble, then one toggle per word with the first word high, then a low postamble, then release. A READ placed exactly one burst after the previous one continues the strobe without a gap.

Top module: `ddr_rd_seq`

## Requirements
- R1: `rdCmd` is sampled only on command edges (even-numbered rising edges of `clk` counted from 0 after reset release). A request presented on any other edge has no effect on any output.
- R2: The first data word of a burst is visible 2×CL clock cycles after the command edge that accepted the READ. CL is 3 when `casLat` = 3 and 2 for any other value.
- R3: During the two clock cycles just before the first word, `dqsOe` is 1, `dqs` is 0 and `dqOe` is 0 (preamble).
- R4: While `dqOe` is 1, `dqs` is 1 on the first word of a burst sequence and inverts on every following word. It is therefore edge-aligned with each new word.
- R5: A burst holds BL words: 2 when `burstSel` = 0, 4 when it is 1, and 8 when it is 2 or 3.
- R6: Word k of a burst reads column (start & ~(BL−1)) | ((start + k) & (BL−1)). The column rises by one and wraps inside the BL-aligned block.
- R7: Each data word is {4'hA, bank[1:0], column[9:0]}.
- R8: In the one cycle after the final word, `dqsOe` is 1, `dqs` is 0 and `dqOe` is 0 (postamble). After that both enables are 0 until the next preamble.
- R9: A READ accepted exactly BL clock cycles after the previous one makes its words follow straight on. The strobe keeps inverting and no postamble or preamble is inserted in between.
- R10: If `autoPre` was 1 with the READ, `preReq` is 1 for exactly one cycle, the cycle right after that burst's final word, with `preBank` equal to the bank. Otherwise `preReq` stays 0.
- R11: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, two cycles per command cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| rdCmd | input | 1 | READ request, taken on command edges |
| bank | input | 2 | Bank select of the READ |
| col | input | 10 | Starting column |
| autoPre | input | 1 | Close the row after this burst |
| casLat | input | 2 | CAS latency in command cycles (2 or 3) |
| burstSel | input | 2 | Burst length code (0:2, 1:4, else 8) |
| dq | output | 16 | Read data word |
| dqOe | output | 1 | Data output enable |
| dqs | output | 1 | Data strobe |
| dqsOe | output | 1 | Strobe output enable |
| preReq | output | 1 | One-cycle precharge request |
| preBank | output | 2 | Bank to precharge |

## Verification
Every result is timed from the command edge E0 that accepted the READ, in `clk` cycles:
- preamble at E0+2CL−2 and E0+2CL−1;
- word k at E0+2CL+k;
- postamble, and any precharge pulse, at E0+2CL+BL.

For a second READ placed back to back, the same offsets are shifted by BL. The bench finds the command edges by counting edges from reset release. It samples on falling edges and compares the complete output state in every cycle from E0 to E0+2CL+2BL+2 against a model built from these offsets, so an event that comes one cycle early or late shows up as a mismatch. It sweeps both latencies, all three burst lengths, columns placed at and across block boundaries, and both auto-precharge settings.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  localparam int BANK_W = 2;
  localparam int COL_W  = 10;
  localparam int CL_MAX = 3;

  typedef struct packed {
    logic              valid;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic              ap;
  } rdCmd_t;

  typedef struct packed {
    logic load;
    logic advance;
  } dpCtl_t;

  function automatic logic [3:0] burstWords(input logic [1:0] sel);
    case (sel)
      2'd0:    burstWords = 4'd2;
      2'd1:    burstWords = 4'd4;
      default: burstWords = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/ddr_rd_ctrl.sv
module ddr_rd_ctrl
  import ddr_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdCmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              autoPre,
  input  logic [1:0]        casLat,
  input  logic [1:0]        burstSel,
  output dpCtl_t            ctl,
  output rdCmd_t            startCmd,
  output logic              dqOe,
  output logic              dqs,
  output logic              dqsOe,
  output logic              preReq,
  output logic [BANK_W-1:0] preBank
);
  localparam int DEPTH = 2 * CL_MAX;

  logic              phase;
  rdCmd_t            pipe [1:DEPTH];
  rdCmd_t            newCmd;
  logic [2:0]        left;
  logic [BANK_W-1:0] curBank;
  logic              curAp;
  logic [3:0]        blen;
  int                startIdx;
  logic              accept, preWin, lastWord, cont, emit;

  always_comb begin
    blen      = burstWords(burstSel);
    startIdx  = (casLat == 2'd3) ? 6 : 4;
    accept    = rdCmd & ~phase;
    newCmd    = '{valid: accept, bank: bank, col: col, ap: autoPre};
    startCmd  = pipe[startIdx];
    preWin    = pipe[startIdx-2].valid | pipe[startIdx-1].valid;
    lastWord  = dqOe && (left == 3'd0);
    cont      = dqOe && (left != 3'd0);
    emit      = startCmd.valid | cont;
    ctl.load    = startCmd.valid;
    ctl.advance = cont & ~startCmd.valid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      for (int i = 1; i <= DEPTH; i++) pipe[i] <= '0;
      left    <= '0;
      curBank <= '0;
      curAp   <= 1'b0;
      dqOe    <= 1'b0;
      dqs     <= 1'b0;
      dqsOe   <= 1'b0;
      preReq  <= 1'b0;
      preBank <= '0;
    end else begin
      phase   <= ~phase;
      pipe[1] <= newCmd;
      for (int i = 2; i <= DEPTH; i++) pipe[i] <= pipe[i-1];
      if (startCmd.valid) begin
        left    <= 3'(blen - 4'd1);
        curBank <= startCmd.bank;
        curAp   <= startCmd.ap;
      end else if (cont) begin
        left <= left - 3'd1;
      end
      dqOe    <= emit;
      dqs     <= startCmd.valid ? 1'b1 : (cont ? ~dqs : 1'b0);
      dqsOe   <= emit | preWin | lastWord;
      preReq  <= lastWord & curAp;
      preBank <= (lastWord & curAp) ? curBank : '0;
    end
  end

  // R1: a command enters the pipe only from an even (command) edge
  p_cmd_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    pipe[1].valid |-> phase);

  // R3: a burst sequence opens only after a low, driven strobe
  p_preamble_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> ($past(dqsOe) && !$past(dqs)));

  // R4: first word high, then one inversion per word
  p_first_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> dqs);
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && $past(dqOe)) |-> (dqs != $past(dqs)));

  // R8: data is never driven without the strobe
  p_oe_pair_r8: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> dqsOe);

  // R10: precharge request is a single-cycle pulse right after a word
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    preReq |=> !preReq);
  p_after_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    preReq |-> $past(dqOe));
endmodule

// File: rtl/ddr_rd_data.sv
module ddr_rd_data
  import ddr_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEED   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BANK_W-1:0] startBank,
  input  logic [COL_W-1:0]  startCol,
  input  logic [1:0]        burstSel,
  output logic [DATA_W-1:0] dq
);
  localparam int PAD_W = DATA_W - BANK_W - COL_W;
  localparam logic [PAD_W-1:0] PAD = PAD_W'(SEED);

  logic [COL_W-1:0]  curCol, mask, nextCol;
  logic [BANK_W-1:0] curBank;

  always_comb begin
    mask    = COL_W'(burstWords(burstSel) - 4'd1);
    nextCol = (curCol & ~mask) | ((curCol + 1'b1) & mask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCol  <= '0;
      curBank <= '0;
      dq      <= '0;
    end else if (ctl.load) begin
      curCol  <= startCol;
      curBank <= startBank;
      dq      <= {PAD, startBank, startCol};
    end else if (ctl.advance) begin
      curCol  <= nextCol;
      dq      <= {PAD, curBank, nextCol};
    end else begin
      dq      <= '0;
    end
  end

  // R6: stepping never leaves the burst-aligned block
  p_col_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> ((curCol & ~mask) == ($past(curCol) & ~mask)));
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
  import ddr_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEED   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdCmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              autoPre,
  input  logic [1:0]        casLat,
  input  logic [1:0]        burstSel,
  output logic [DATA_W-1:0] dq,
  output logic              dqOe,
  output logic              dqs,
  output logic              dqsOe,
  output logic              preReq,
  output logic [BANK_W-1:0] preBank
);
  dpCtl_t ctl;
  rdCmd_t startCmd;

  ddr_rd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .bank(bank), .col(col),
    .autoPre(autoPre), .casLat(casLat), .burstSel(burstSel),
    .ctl(ctl), .startCmd(startCmd), .dqOe(dqOe), .dqs(dqs),
    .dqsOe(dqsOe), .preReq(preReq), .preBank(preBank)
  );

  ddr_rd_data #(.DATA_W(DATA_W), .SEED(SEED)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startBank(startCmd.bank),
    .startCol(startCmd.col), .burstSel(burstSel), .dq(dq)
  );
endmodule

// File: tb/ddr_rd_seq_bench.sv
module ddr_rd_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdCmd = 1'b0;
  logic [1:0]  bank = '0;
  logic [9:0]  col = '0;
  logic        autoPre = 1'b0;
  logic [1:0]  casLat = 2'd2;
  logic [1:0]  burstSel = 2'd0;
  logic [15:0] dq;
  logic        dqOe, dqs, dqsOe, preReq;
  logic [1:0]  preBank;

  int tests = 0;
  int fails = 0;
  int edgeCnt = 0;
  int tCl, tBl, nB;
  logic [1:0] cb [2];
  logic [9:0] cc [2];
  logic       ca [2];

  ddr_rd_seq u_ddr_rd_seq (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .bank(bank), .col(col),
    .autoPre(autoPre), .casLat(casLat), .burstSel(burstSel), .dq(dq),
    .dqOe(dqOe), .dqs(dqs), .dqsOe(dqsOe), .preReq(preReq), .preBank(preBank)
  );

  always #10 clk = ~clk;
  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  function automatic logic [21:0] actual();
    return {dqOe, dqsOe, dqs, preReq, preBank, dq};
  endfunction

  task automatic check(input string tag, input logic [21:0] exp);
    tests++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, actual(), exp, $time);
    end
  endtask

  // expected state m cycles after the accepting edge
  task automatic checkCycle(input int m);
    logic [21:0] e = '0;
    string tag = "R8 release";
    int p = m - 2 * tCl;
    logic [9:0] msk = 10'(tBl - 1);
    if (p == -2 || p == -1) begin
      e[20] = 1'b1; tag = "R3 preamble";
    end else if (p >= 0 && p < nB * tBl) begin
      int k = p / tBl;
      int o = p % tBl;
      logic [9:0] c = (cc[k] & ~msk) | ((cc[k] + 10'(o)) & msk);
      e[21] = 1'b1; e[20] = 1'b1; e[19] = (p % 2 == 0);
      e[15:0] = {4'hA, cb[k], c};
      tag = (p == 0) ? "R2 first word" : (nB == 2 && p == tBl) ? "R9 seamless" : "R4 R6 R7 data";
    end else if (p == nB * tBl) begin
      e[20] = 1'b1; tag = "R5 R8 postamble";
    end
    for (int k = 0; k < nB; k++)
      if (p == (k + 1) * tBl && ca[k]) begin
        e[18] = 1'b1; e[17:16] = cb[k]; tag = {tag, " R10"};
      end
    check(tag, e);
  endtask

  task automatic alignCmd();
    @(negedge clk);
    while (edgeCnt % 2 != 0) @(negedge clk);
  endtask

  task automatic drive(input int k);
    rdCmd = 1'b1; bank = cb[k]; col = cc[k]; autoPre = ca[k];
  endtask

  task automatic runTest();
    alignCmd();
    drive(0);
    @(negedge clk);
    rdCmd = 1'b0;
    for (int m = 0; m <= 2 * tCl + nB * tBl + 2; m++) begin
      checkCycle(m);
      if (nB == 2 && m == tBl - 1) drive(1);
      if (nB == 2 && m == tBl) rdCmd = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int colsList [7] = '{0, 1, 3, 6, 7, 1023, 677};
    repeat (3) begin
      @(negedge clk);
      check("R11 reset", 22'd0);
    end
    rstN = 1'b1;
    edgeCnt = 0;

    // R1: request on an odd edge only
    tCl = 2; tBl = 2;
    alignCmd();
    @(negedge clk);
    rdCmd = 1'b1; bank = 2'd1; col = 10'd5; autoPre = 1'b1;
    @(negedge clk);
    rdCmd = 1'b0;
    for (int m = 0; m < 16; m++) begin
      check("R1 odd edge ignored", 22'd0);
      @(negedge clk);
    end

    for (int cl = 2; cl <= 3; cl++)
      for (int bs = 0; bs < 3; bs++) begin
        tCl = cl; tBl = 2 << bs;
        casLat = 2'(cl); burstSel = 2'(bs);
        nB = 1;
        for (int i = 0; i < 7; i++) begin
          cc[0] = 10'(colsList[i]); cb[0] = 2'(colsList[i] % 4); ca[0] = (i % 2 == 1);
          runTest();
        end
        nB = 2;
        for (int i = 0; i < 3; i++) begin
          cc[0] = 10'(colsList[i + 2]); cb[0] = 2'(i);     ca[0] = (i != 1);
          cc[1] = 10'(colsList[i + 4]); cb[1] = 2'(i + 1); ca[1] = (i != 0);
          runTest();
        end
      end

    // R5: code 3 behaves as 8 words
    tCl = 2; tBl = 8; casLat = 2'd2; burstSel = 2'd3; nB = 1;
    cc[0] = 10'd13; cb[0] = 2'd3; ca[0] = 1'b1;
    runTest();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule